// File: doc/BRIEF.md
# Display Window Write Sequencer

This block fills a rectangular window of a display controller's pixel RAM. A start pulse captures a start column, end column, start row and end row. The block then sends a fixed preamble: a row-range command with the two row bytes, a column-range command with the two column bytes, and a write-RAM command. After the preamble it forwards pixel bytes from an upstream valid/ready stream, one row per transaction, until the end row has been written.

Bytes leave on a byte-wide valid/ready interface toward a serializer. Each byte carries a command/data type bit and start-of-transaction and end-of-transaction flags. When the serializer accepts the final byte of a transaction, it reports that transaction's status on the error input. In 3-wire mode the type bit travels in-band, and the serializer adds it as a ninth bit. In 4-wire mode a separate D/C pin also carries the type, and the preamble is divided the way a D/C-switching link needs. A one-cycle done pulse with an error flag ends every window.

Top module: `wws_window_writer`

## Requirements
- R1: In 3-wire mode the preamble is one transaction of seven bytes, in this order: row command (default 8'h75), start row, end row, column command (default 8'h15), start column, end column, write-RAM command (default 8'h5C). The first byte carries the start flag and the seventh carries the end flag. Command bytes have the type bit at 0 and address bytes have it at 1.
- R2: In 4-wire mode the same seven bytes go out in five transactions: each command byte alone, and each pair of address bytes together.
- R3: Rows go out from the start row to the end row inclusive. Each row is its own transaction, with the start flag on its first byte and the end flag on its last byte.
- R4: Each row holds (end column + 1 - start column) x 2 bytes. These are the upstream pixel bytes, in arrival order and with the type bit at 1.
- R5: A window is rejected if a row would exceed 128 bytes, if the end column is below the start column, or if the end row is below the start row. The cycle after the start, done and error go high, and no byte is sent.
- R6: In 4-wire mode the D/C pin is low for every command byte and high for every address byte.
- R7: In 4-wire mode the D/C pin is high through all pixel rows.
- R8: In 3-wire mode the D/C pin keeps the level it had before the start.
- R9: If the error input is high when the final byte of any transaction is accepted, done and error go high in the next cycle and no further byte is offered.
- R10: After the final pixel byte of the end row is accepted, done pulses in the next cycle with error low. Done stays low at every earlier point.
- R11: The pixel ready output is high only while a pixel row is being streamed. No pixel is taken during the preamble or while idle.
- R12: After reset: no byte valid, done low, pixel ready low, D/C high.
- R13: A start pulse that arrives while a window is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a window write |
| four_wire_i | input | 1 | 1 = D/C pin mode, 0 = in-band type bit mode |
| col_from_i | input | 8 | Start column |
| col_to_i | input | 8 | End column |
| row_from_i | input | 8 | Start row |
| row_to_i | input | 8 | End row |
| pix_valid_i | input | 1 | Upstream pixel byte valid |
| pix_data_i | input | 8 | Upstream pixel byte |
| pix_ready_o | output | 1 | Pixel byte taken |
| out_valid_o | output | 1 | Byte offered to serializer |
| out_ready_i | input | 1 | Serializer accepts byte |
| out_byte_o | output | 8 | Byte value |
| out_is_data_o | output | 1 | Type bit: 0 command, 1 data |
| out_first_o | output | 1 | First byte of a transaction |
| out_last_o | output | 1 | Last byte of a transaction |
| xact_err_i | input | 1 | Transaction status, sampled with the accepted last byte |
| dc_o | output | 1 | D/C pin |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag, valid with done |

## Verification
The first preamble byte is offered in the cycle after the start edge. Each later byte is offered in the cycle after the previous one is accepted. Pixel bytes and their flags pass through combinationally in the cycle they arrive. Done and error are registered, so they are due exactly one cycle after the last accepted byte, or one cycle after a rejected start. The bench drives inputs at the falling edge and reads outputs shortly after. It compares each accepted byte, as it is accepted, against a precomputed transcript. It looks for done only at the falling edge that follows the transcript's final byte, and requires done low at all earlier samples.

// File: rtl/wws_pkg.sv
package wws_pkg;

    localparam int unsigned WWS_BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_ROWS
    } wws_state_e;

    typedef enum logic [2:0] {
        PS_ROW_CMD,
        PS_ROW_LO,
        PS_ROW_HI,
        PS_COL_CMD,
        PS_COL_LO,
        PS_COL_HI,
        PS_RAM_CMD
    } pre_step_e;

    typedef struct packed {
        logic [WWS_BYTE_W-1:0] val;
        logic                  is_data;
        logic                  first;
        logic                  last;
    } out_beat_t;

    function automatic logic step_is_cmd(pre_step_e s);
        return (s == PS_ROW_CMD) || (s == PS_COL_CMD) || (s == PS_RAM_CMD);
    endfunction

    // Start flag: whole preamble is one transaction in-band, split otherwise.
    function automatic logic step_opens(pre_step_e s, logic four);
        if (four)
            return (s != PS_ROW_HI) && (s != PS_COL_HI);
        return s == PS_ROW_CMD;
    endfunction

    function automatic logic step_closes(pre_step_e s, logic four);
        if (four)
            return (s != PS_ROW_LO) && (s != PS_COL_LO);
        return s == PS_RAM_CMD;
    endfunction

endpackage

// File: rtl/wws_span.sv
module wws_span
    import wws_pkg::*;
#(
    parameter int unsigned MAX_ROW_BYTES = 128,
    parameter int unsigned LEN_W         = WWS_BYTE_W + 2
) (
    input  logic [WWS_BYTE_W-1:0] col_from_i,
    input  logic [WWS_BYTE_W-1:0] col_to_i,
    input  logic [WWS_BYTE_W-1:0] row_from_i,
    input  logic [WWS_BYTE_W-1:0] row_to_i,
    output logic [LEN_W-1:0]      row_len_o,
    output logic                  reject_o
);

    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_ROW_BYTES);

    logic [LEN_W-1:0] col_diff;
    logic             cols_reversed;
    logic             rows_reversed;

    always_comb begin
        col_diff      = LEN_W'(col_to_i) - LEN_W'(col_from_i);
        row_len_o     = (col_diff + LEN_W'(1)) << 1;
        cols_reversed = col_to_i < col_from_i;
        rows_reversed = row_to_i < row_from_i;
        reject_o      = cols_reversed || rows_reversed || (row_len_o > LIMIT);
    end

endmodule

// File: rtl/wws_ctrl.sv
module wws_ctrl
    import wws_pkg::*;
#(
    parameter int unsigned LEN_W = WWS_BYTE_W + 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  four_wire_i,
    input  logic                  reject_i,
    input  logic [LEN_W-1:0]      row_len_i,
    input  logic [WWS_BYTE_W-1:0] col_from_i,
    input  logic [WWS_BYTE_W-1:0] col_to_i,
    input  logic [WWS_BYTE_W-1:0] row_from_i,
    input  logic [WWS_BYTE_W-1:0] row_to_i,
    input  logic                  accept_i,
    input  logic                  beat_last_i,
    input  logic                  xact_err_i,
    output wws_state_e            state_o,
    output pre_step_e             step_o,
    output logic                  four_q_o,
    output logic [LEN_W-1:0]      len_q_o,
    output logic [LEN_W-1:0]      byte_idx_o,
    output logic [WWS_BYTE_W-1:0] col_from_q_o,
    output logic [WWS_BYTE_W-1:0] col_to_q_o,
    output logic [WWS_BYTE_W-1:0] row_from_q_o,
    output logic [WWS_BYTE_W-1:0] row_to_q_o,
    output logic                  done_o,
    output logic                  err_o
);

    logic [WWS_BYTE_W-1:0] row_cur;
    logic                  row_end;
    logic                  win_end;
    logic                  fail_now;

    assign row_end  = byte_idx_o == (len_q_o - LEN_W'(1));
    assign win_end  = row_end && (row_cur == row_to_q_o);
    assign fail_now = accept_i && beat_last_i && xact_err_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o      <= ST_IDLE;
            step_o       <= PS_ROW_CMD;
            four_q_o     <= 1'b0;
            len_q_o      <= '0;
            byte_idx_o   <= '0;
            row_cur      <= '0;
            col_from_q_o <= '0;
            col_to_q_o   <= '0;
            row_from_q_o <= '0;
            row_to_q_o   <= '0;
            done_o       <= 1'b0;
            err_o        <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            unique case (state_o)
                ST_IDLE: begin
                    if (start_i) begin
                        if (reject_i) begin
                            done_o <= 1'b1;
                            err_o  <= 1'b1;
                        end else begin
                            state_o      <= ST_PRE;
                            step_o       <= PS_ROW_CMD;
                            four_q_o     <= four_wire_i;
                            len_q_o      <= row_len_i;
                            col_from_q_o <= col_from_i;
                            col_to_q_o   <= col_to_i;
                            row_from_q_o <= row_from_i;
                            row_to_q_o   <= row_to_i;
                        end
                    end
                end
                ST_PRE: begin
                    if (fail_now) begin
                        state_o <= ST_IDLE;
                        done_o  <= 1'b1;
                        err_o   <= 1'b1;
                    end else if (accept_i) begin
                        if (step_o == PS_RAM_CMD) begin
                            state_o    <= ST_ROWS;
                            row_cur    <= row_from_q_o;
                            byte_idx_o <= '0;
                        end else begin
                            step_o <= pre_step_e'(step_o + 3'd1);
                        end
                    end
                end
                ST_ROWS: begin
                    if (fail_now) begin
                        state_o <= ST_IDLE;
                        done_o  <= 1'b1;
                        err_o   <= 1'b1;
                    end else if (accept_i) begin
                        if (win_end) begin
                            state_o <= ST_IDLE;
                            done_o  <= 1'b1;
                        end else if (row_end) begin
                            row_cur    <= row_cur + WWS_BYTE_W'(1);
                            byte_idx_o <= '0;
                        end else begin
                            byte_idx_o <= byte_idx_o + LEN_W'(1);
                        end
                    end
                end
                default: state_o <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wws_emit.sv
module wws_emit
    import wws_pkg::*;
#(
    parameter logic [WWS_BYTE_W-1:0] ROW_CMD = 8'h75,
    parameter logic [WWS_BYTE_W-1:0] COL_CMD = 8'h15,
    parameter logic [WWS_BYTE_W-1:0] RAM_CMD = 8'h5C,
    parameter int unsigned           LEN_W   = WWS_BYTE_W + 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wws_state_e            state_i,
    input  pre_step_e             step_i,
    input  logic                  four_i,
    input  logic [LEN_W-1:0]      len_i,
    input  logic [LEN_W-1:0]      byte_idx_i,
    input  logic [WWS_BYTE_W-1:0] col_from_i,
    input  logic [WWS_BYTE_W-1:0] col_to_i,
    input  logic [WWS_BYTE_W-1:0] row_from_i,
    input  logic [WWS_BYTE_W-1:0] row_to_i,
    input  logic                  pix_valid_i,
    input  logic [WWS_BYTE_W-1:0] pix_data_i,
    input  logic                  out_ready_i,
    output logic                  pix_ready_o,
    output logic                  out_valid_o,
    output out_beat_t             beat_o,
    output logic                  dc_o
);

    logic dc_hold;
    logic [WWS_BYTE_W-1:0] pre_val;

    always_comb begin
        unique case (step_i)
            PS_ROW_CMD: pre_val = ROW_CMD;
            PS_ROW_LO:  pre_val = row_from_i;
            PS_ROW_HI:  pre_val = row_to_i;
            PS_COL_CMD: pre_val = COL_CMD;
            PS_COL_LO:  pre_val = col_from_i;
            PS_COL_HI:  pre_val = col_to_i;
            PS_RAM_CMD: pre_val = RAM_CMD;
            default:    pre_val = RAM_CMD;
        endcase
    end

    always_comb begin
        out_valid_o = 1'b0;
        pix_ready_o = 1'b0;
        beat_o      = '0;
        unique case (state_i)
            ST_PRE: begin
                out_valid_o    = 1'b1;
                beat_o.val     = pre_val;
                beat_o.is_data = !step_is_cmd(step_i);
                beat_o.first   = step_opens(step_i, four_i);
                beat_o.last    = step_closes(step_i, four_i);
            end
            ST_ROWS: begin
                out_valid_o    = pix_valid_i;
                pix_ready_o    = out_ready_i;
                beat_o.val     = pix_data_i;
                beat_o.is_data = 1'b1;
                beat_o.first   = byte_idx_i == '0;
                beat_o.last    = byte_idx_i == (len_i - LEN_W'(1));
            end
            default: ;
        endcase
    end

    assign dc_o = ((state_i != ST_IDLE) && four_i) ? beat_o.is_data : dc_hold;

    always_ff @(posedge clk) begin
        if (rst) dc_hold <= 1'b1;
        else     dc_hold <= dc_o;
    end

endmodule

// File: rtl/wws_window_writer.sv
module wws_window_writer
    import wws_pkg::*;
#(
    parameter logic [WWS_BYTE_W-1:0] ROW_CMD       = 8'h75,
    parameter logic [WWS_BYTE_W-1:0] COL_CMD       = 8'h15,
    parameter logic [WWS_BYTE_W-1:0] RAM_CMD       = 8'h5C,
    parameter int unsigned           MAX_ROW_BYTES = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       four_wire_i,
    input  logic [7:0] col_from_i,
    input  logic [7:0] col_to_i,
    input  logic [7:0] row_from_i,
    input  logic [7:0] row_to_i,
    input  logic       pix_valid_i,
    input  logic [7:0] pix_data_i,
    output logic       pix_ready_o,
    output logic       out_valid_o,
    input  logic       out_ready_i,
    output logic [7:0] out_byte_o,
    output logic       out_is_data_o,
    output logic       out_first_o,
    output logic       out_last_o,
    input  logic       xact_err_i,
    output logic       dc_o,
    output logic       done_o,
    output logic       err_o
);

    localparam int unsigned LEN_W = WWS_BYTE_W + 2;

    logic [LEN_W-1:0]      row_len;
    logic                  reject;
    wws_state_e            state;
    pre_step_e             step;
    logic                  four_q;
    logic [LEN_W-1:0]      len_q;
    logic [LEN_W-1:0]      byte_idx;
    logic [WWS_BYTE_W-1:0] cf_q, ct_q, rf_q, rt_q;
    out_beat_t             beat;
    logic                  accept;
    logic                  busy;

    assign accept = out_valid_o && out_ready_i;
    assign busy   = state != ST_IDLE;

    wws_span #(.MAX_ROW_BYTES(MAX_ROW_BYTES), .LEN_W(LEN_W)) u_span (
        .col_from_i (col_from_i),
        .col_to_i   (col_to_i),
        .row_from_i (row_from_i),
        .row_to_i   (row_to_i),
        .row_len_o  (row_len),
        .reject_o   (reject)
    );

    wws_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .four_wire_i  (four_wire_i),
        .reject_i     (reject),
        .row_len_i    (row_len),
        .col_from_i   (col_from_i),
        .col_to_i     (col_to_i),
        .row_from_i   (row_from_i),
        .row_to_i     (row_to_i),
        .accept_i     (accept),
        .beat_last_i  (beat.last),
        .xact_err_i   (xact_err_i),
        .state_o      (state),
        .step_o       (step),
        .four_q_o     (four_q),
        .len_q_o      (len_q),
        .byte_idx_o   (byte_idx),
        .col_from_q_o (cf_q),
        .col_to_q_o   (ct_q),
        .row_from_q_o (rf_q),
        .row_to_q_o   (rt_q),
        .done_o       (done_o),
        .err_o        (err_o)
    );

    wws_emit #(
        .ROW_CMD (ROW_CMD),
        .COL_CMD (COL_CMD),
        .RAM_CMD (RAM_CMD),
        .LEN_W   (LEN_W)
    ) u_emit (
        .clk         (clk),
        .rst         (rst),
        .state_i     (state),
        .step_i      (step),
        .four_i      (four_q),
        .len_i       (len_q),
        .byte_idx_i  (byte_idx),
        .col_from_i  (cf_q),
        .col_to_i    (ct_q),
        .row_from_i  (rf_q),
        .row_to_i    (rt_q),
        .pix_valid_i (pix_valid_i),
        .pix_data_i  (pix_data_i),
        .out_ready_i (out_ready_i),
        .pix_ready_o (pix_ready_o),
        .out_valid_o (out_valid_o),
        .beat_o      (beat),
        .dc_o        (dc_o)
    );

    assign out_byte_o    = beat.val;
    assign out_is_data_o = beat.is_data;
    assign out_first_o   = beat.first;
    assign out_last_o    = beat.last;

endmodule

// File: rtl/wws_checker.sv
module wws_checker (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic four_q,
    input logic out_valid,
    input logic out_ready,
    input logic out_last,
    input logic out_is_data,
    input logic xact_err,
    input logic pix_ready,
    input logic dc,
    input logic done,
    input logic err
);

    assert_dc_follows_type_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && four_q && out_valid) |-> (dc == out_is_data));

    assert_rows_dc_high_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && four_q && pix_ready) |-> dc);

    assert_stop_on_error_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last && xact_err) |=> (done && err && !out_valid));

    assert_err_needs_done_R9: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    assert_clean_done_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> $past(out_valid && out_ready && out_last));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!out_valid && !pix_ready));

    assert_pixels_are_data_R11: assert property (@(posedge clk) disable iff (rst)
        pix_ready |-> out_is_data);

endmodule

bind wws_window_writer wws_checker u_wws_checker (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .four_q      (four_q),
    .out_valid   (out_valid_o),
    .out_ready   (out_ready_i),
    .out_last    (out_last_o),
    .out_is_data (out_is_data_o),
    .xact_err    (xact_err_i),
    .pix_ready   (pix_ready_o),
    .dc          (dc_o),
    .done        (done_o),
    .err         (err_o)
);

// File: tb/test_wws_window_writer.sv
module test_wws_window_writer;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic       start_i = 0, four_wire_i = 0;
    logic [7:0] col_from_i = 0, col_to_i = 0, row_from_i = 0, row_to_i = 0;
    logic       pix_valid_i = 0;
    logic [7:0] pix_data_i = 0;
    logic       pix_ready_o, out_valid_o, out_ready_i = 0;
    logic [7:0] out_byte_o;
    logic       out_is_data_o, out_first_o, out_last_o;
    logic       xact_err_i = 0, dc_o, done_o, err_o;

    wws_window_writer i_wws_window_writer (
        .clk(clk), .rst(rst), .start_i(start_i), .four_wire_i(four_wire_i),
        .col_from_i(col_from_i), .col_to_i(col_to_i),
        .row_from_i(row_from_i), .row_to_i(row_to_i),
        .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i), .pix_ready_o(pix_ready_o),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_byte_o(out_byte_o),
        .out_is_data_o(out_is_data_o), .out_first_o(out_first_o), .out_last_o(out_last_o),
        .xact_err_i(xact_err_i), .dc_o(dc_o), .done_o(done_o), .err_o(err_o)
    );

    typedef struct {
        logic [7:0] b;
        bit d, f, l, pix;
        int x;
    } beat_t;

    beat_t      q[$];
    int         n_cmp = 0;
    int         n_bad = 0;
    logic [7:0] src = 8'h00;
    bit         pv = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void push(logic [7:0] b, bit d, bit f, bit l, bit pix, int x);
        beat_t e;
        e.b = b; e.d = d; e.f = f; e.l = l; e.pix = pix; e.x = x;
        q.push_back(e);
    endfunction

    // Expected transcript, from R1..R4.
    function automatic int build(int cf, int ct, int rf, int rt, bit four);
        logic [7:0] pb[7];
        bit         pd[7];
        int         x, len;
        pb = '{8'h75, rf[7:0], rt[7:0], 8'h15, cf[7:0], ct[7:0], 8'h5C};
        pd = '{0, 1, 1, 0, 1, 1, 0};
        q.delete();
        x = 0;
        for (int i = 0; i < 7; i++) begin
            if (four) begin
                x = (i < 1) ? 0 : (i < 3) ? 1 : (i < 4) ? 2 : (i < 6) ? 3 : 4;
                push(pb[i], pd[i], (i != 2 && i != 5), (i != 1 && i != 4), 0, x);
            end else begin
                push(pb[i], pd[i], i == 0, i == 6, 0, 0);
            end
        end
        len = (ct + 1 - cf) * 2;
        for (int r = rf; r <= rt; r++) begin
            x++;
            for (int k = 0; k < len; k++) push(8'h00, 1, k == 0, k == len - 1, 1, x);
        end
        return x + 1;
    endfunction

    task automatic run(int cf, int ct, int rf, int rt, bit four, int err_x, bit poke);
        int   cyc;
        bit   exp_err, fin;
        logic dc0;
        beat_t e;
        void'(build(cf, ct, rf, rt, four));
        exp_err = 0;
        fin = 0;
        @(negedge clk);
        dc0 = dc_o;
        start_i = 1; four_wire_i = four;
        col_from_i = cf[7:0]; col_to_i = ct[7:0]; row_from_i = rf[7:0]; row_to_i = rt[7:0];
        @(negedge clk);
        cyc = 0;
        while (!fin) begin
            if (poke && cyc == 4) begin
                // R13: a start while busy must not disturb the transcript
                start_i = 1; four_wire_i = !four;
                col_from_i = 0; col_to_i = 0; row_from_i = 0; row_to_i = 0;
            end else begin
                start_i = 0;
            end
            out_ready_i = ($urandom % 4) != 0;
            if (!pv) pv = ($urandom % 3) != 0;
            pix_valid_i = pv;
            pix_data_i = src;
            xact_err_i = out_ready_i && q.size() > 0 && q[0].l && q[0].x == err_x;
            #1;
            chk(done_o == 0, "R10 early done", done_o, 0);
            if (pix_ready_o)
                chk(q.size() > 0 && q[0].pix, "R11 pixel taken outside row", 1, 0);
            if (!four)
                chk(dc_o == dc0, "R8 dc moved in-band mode", dc_o, dc0);
            if (out_valid_o && out_ready_i) begin
                e = q.pop_front();
                if (e.pix) begin
                    chk(out_byte_o == src, "R4 pixel byte", out_byte_o, src);
                    chk(out_first_o == e.f && out_last_o == e.l, "R3 row flags",
                        {out_first_o, out_last_o}, {e.f, e.l});
                    chk(out_is_data_o == 1, "R4 pixel type", out_is_data_o, 1);
                    if (four) chk(dc_o == 1, "R7 dc in rows", dc_o, 1);
                end else if (four) begin
                    chk(out_byte_o == e.b && out_is_data_o == e.d, "R2 preamble byte",
                        out_byte_o, e.b);
                    chk(out_first_o == e.f && out_last_o == e.l, "R2 preamble flags",
                        {out_first_o, out_last_o}, {e.f, e.l});
                    chk(dc_o == e.d, "R6 dc level", dc_o, e.d);
                end else begin
                    chk(out_byte_o == e.b && out_is_data_o == e.d, "R1 preamble byte",
                        out_byte_o, e.b);
                    chk(out_first_o == e.f && out_last_o == e.l, "R1 preamble flags",
                        {out_first_o, out_last_o}, {e.f, e.l});
                end
                if (e.l && e.x == err_x) begin
                    exp_err = 1;
                    q.delete();
                end
                if (q.size() == 0) fin = 1;
            end
            if (pix_valid_i && pix_ready_o) begin
                pv = 0;
                src = src + 8'd1;
            end
            if (!fin) begin
                @(negedge clk);
                cyc++;
                if (cyc > 5000) begin
                    chk(0, "R10 run stalled", cyc, 0);
                    fin = 1;
                end
            end
        end
        @(negedge clk);
        start_i = 0; out_ready_i = 0; xact_err_i = 0; pix_valid_i = 0; pv = 0;
        #1;
        chk(done_o == 1, exp_err ? "R9 done after error" : "R10 done", done_o, 1);
        chk(err_o == exp_err, exp_err ? "R9 error flag" : "R10 error flag", err_o, exp_err);
        chk(out_valid_o == 0, "R9 quiet after end", out_valid_o, 0);
    endtask

    task automatic reject(int cf, int ct, int rf, int rt);
        @(negedge clk);
        start_i = 1; four_wire_i = 0;
        col_from_i = cf[7:0]; col_to_i = ct[7:0]; row_from_i = rf[7:0]; row_to_i = rt[7:0];
        @(negedge clk);
        start_i = 0;
        #1;
        chk(done_o == 1 && err_o == 1, "R5 reject done/err", {done_o, err_o}, 3);
        chk(out_valid_o == 0, "R5 nothing sent", out_valid_o, 0);
        @(negedge clk);
        #1;
        chk(out_valid_o == 0 && done_o == 0, "R5 stays idle", {out_valid_o, done_o}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cf, ct, rf, rt, nx, ex;
        bit four;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        #1;
        chk(out_valid_o == 0 && done_o == 0 && pix_ready_o == 0, "R12 reset outputs",
            {out_valid_o, done_o, pix_ready_o}, 0);
        chk(dc_o == 1, "R12 reset dc", dc_o, 1);

        run(3, 3, 7, 7, 0, -1, 0);       // smallest window, in-band
        run(3, 4, 1, 3, 1, -1, 0);       // D/C pin mode, several rows
        run(10, 73, 0, 0, 0, -1, 0);     // exactly 128 bytes per row
        reject(10, 74, 0, 0);            // 130 bytes
        reject(5, 4, 0, 0);              // reversed columns
        reject(0, 1, 5, 4);              // reversed rows
        run(0, 1, 0, 2, 0, 0, 0);        // error on in-band preamble
        run(0, 1, 0, 2, 1, 2, 0);        // error on a D/C-mode command
        run(2, 3, 4, 7, 0, 2, 0);        // error on the second row
        run(0, 5, 2, 4, 1, -1, 1);       // start while busy
        run(0, 5, 2, 4, 0, -1, 1);

        for (int i = 0; i < 24; i++) begin
            cf = $urandom % 100;
            ct = cf + ($urandom % 6);
            rf = $urandom % 60;
            rt = rf + ($urandom % 3);
            four = $urandom % 2;
            nx = build(cf, ct, rf, rt, four);
            ex = (($urandom % 4) == 0) ? int'($urandom % nx) : -1;
            run(cf, ct, rf, rt, four, ex, ($urandom % 3) == 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule